// File: doc/BRIEF.md
# Pulse-Interval Tag Link Layer

This block is the link layer of a low-frequency tag emulator. The reader signals bits by briefly dropping its field. A thresholded field-present input therefore shows a rising edge at the end of every gap. The block times each edge-to-edge interval in carrier periods and turns it into a bit. A long silence closes the frame, which is then handed out MSB-first packed. A carrier-period tick is derived internally from the system clock by a parameterised divider. The field input passes through a two-flop synchroniser.

When the command layer answers, it presents a payload and its bit count. The block waits until a fixed delay has passed since the reader's last edge. It then drives the coil-load output with five start ones, followed by the payload, all Manchester coded. The coil stays unloaded at all other times.

Top module: `lf_gap_responder`

## Requirements
- R1: After reset `coil_load` is 0, `frame_valid` is 0 and `frame_len` is 0.
- R2: The interval between two heard rising edges of `field_in` is counted in carrier periods of `DIV` clocks. An interval of 15 to 23 periods stores a 0, and an interval of 24 to 40 periods stores a 1.
- R3: An interval shorter than 15 periods stores nothing. The next interval is still measured from that edge.
- R4: Once more than 40 periods have passed since the last heard edge, a frame holding at least one bit is delivered. Delivery is a single-cycle `frame_valid` pulse with `frame_len` equal to the bit count, and the next frame starts at bit 0.
- R5: The interval ending at the first heard edge after such a silence is discarded, even if the 8-bit period counter has wrapped to a value in the valid range.
- R6: Bit n of a frame is placed at `frame_data[79-n]`. Only the first 80 bits are kept, and `frame_len` never exceeds 80.
- R7: A `rsp_valid` pulse accepted while idle starts the reply. The reply starts in the carrier period where 200 periods have elapsed since the last heard reader edge.
- R8: A reply is five 1 bits followed by `min(rsp_len,80)` payload bits, taken from `rsp_data[79]` downward. A zero length sends only the five start bits.
- R9: Each reply bit lasts 31 periods. A 1 loads the coil (`coil_load`=1) for the first 15 periods and releases it for the other 16. A 0 does the opposite.
- R10: `coil_load` is 0 whenever no reply is being sent, including directly after the last reply bit.
- R11: From acceptance of a reply until its last bit, field edges store no bits and do not restart the delay count, and further `rsp_valid` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_in | input | 1 | Thresholded field-present signal, asynchronous |
| rsp_valid | input | 1 | One-cycle request to send a reply |
| rsp_data | input | 80 | Reply payload, first bit at bit 79 |
| rsp_len | input | 7 | Reply payload length in bits |
| coil_load | output | 1 | 1 shorts (loads) the coil |
| frame_valid | output | 1 | One-cycle pulse with a completed frame |
| frame_data | output | 80 | Received frame, first bit at bit 79 |
| frame_len | output | 7 | Received frame length in bits |

## Verification
The bench drives intervals at exactly 14, 15, 23, 24 and 40 periods. A design that is off by one in the period count or in a threshold would store the wrong bit, or drop or keep an edge wrongly. One gap is made 276 periods long so the counter wraps to 20. A design that trusts the counter after a silence would then add a spurious 0. A train of 85 bits checks that bits beyond 80 are dropped rather than overwriting the packed frame. The replies are decoded from the coil waveform. The field toggles during a reply and a second request arrives. A design that listened while sending would either move the reply start or deliver a phantom frame afterwards.

// File: rtl/lf_gap_responder.sv
module lf_gap_responder #(
  parameter int DIV      = 4,
  parameter int CW       = 8,
  parameter int MAX_BITS = 80,
  parameter int T0_MIN   = 15,
  parameter int T1_MIN   = 24,
  parameter int T_EOF    = 40,
  parameter int T_REPLY  = 200,
  parameter int SOF_BITS = 5,
  parameter int HALF     = 15,
  parameter int BIT_T    = 31
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 field_in,
  input  logic                                 rsp_valid,
  input  logic [MAX_BITS-1:0]                  rsp_data,
  input  logic [$clog2(MAX_BITS+1)-1:0]        rsp_len,
  output logic                                 coil_load,
  output logic                                 frame_valid,
  output logic [MAX_BITS-1:0]                  frame_data,
  output logic [$clog2(MAX_BITS+1)-1:0]        frame_len
);
  localparam int LW = $clog2(MAX_BITS + 1);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IW = $clog2(SOF_BITS + MAX_BITS);
  localparam int BW = $clog2(BIT_T);
  localparam logic [DW-1:0] D_END  = DW'(DIV - 1);
  localparam logic [CW-1:0] C_T0   = CW'(T0_MIN);
  localparam logic [CW-1:0] C_T1   = CW'(T1_MIN);
  localparam logic [CW-1:0] C_EOF  = CW'(T_EOF);
  localparam logic [CW-1:0] C_GO   = CW'(T_REPLY - 1);
  localparam logic [BW-1:0] B_HALF = BW'(HALF);
  localparam logic [BW-1:0] B_END  = BW'(BIT_T - 1);
  localparam logic [LW-1:0] L_MAX  = LW'(MAX_BITS);
  localparam logic [LW-1:0] L_TOP  = LW'(MAX_BITS - 1);
  localparam logic [IW-1:0] I_SOF  = IW'(SOF_BITS);
  localparam logic [IW-1:0] I_TOP  = IW'(MAX_BITS - 1 + SOF_BITS);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} tx_st_t;

  logic [DW-1:0]       div;
  logic [2:0]          fs;
  logic [CW-1:0]       cnt;
  logic                ovf;
  logic [LW-1:0]       pos;
  logic [MAX_BITS-1:0] shreg;
  tx_st_t              st;
  logic [MAX_BITS-1:0] tx_data;
  logic [IW-1:0]       idx, last;
  logic [BW-1:0]       bt;

  wire tick    = (div == D_END);
  wire rise    = fs[1] & ~fs[2];
  wire busy    = (st != S_IDLE);
  wire hear    = rise & ~busy;
  wire sending = (st == S_SEND);
  wire cur_bit = (idx < I_SOF) ? 1'b1 : tx_data[I_TOP - idx];
  wire [LW-1:0] eff_len = (rsp_len > L_MAX) ? L_MAX : rsp_len;

  assign coil_load = sending & (cur_bit ? (bt < B_HALF) : (bt >= B_HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      fs  <= '0;
      cnt <= '0;
    end else begin
      div <= tick ? '0 : div + 1'b1;
      fs  <= {fs[1:0], field_in};
      cnt <= hear ? CW'(tick) : cnt + CW'(tick);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf         <= 1'b1;
      pos         <= '0;
      shreg       <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      frame_len   <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (hear) begin
        if (!ovf && cnt >= C_T0 && cnt <= C_EOF && pos < L_MAX) begin
          shreg[L_TOP - pos] <= (cnt >= C_T1);
          pos <= pos + 1'b1;
        end
        ovf <= 1'b0;
      end else if (cnt > C_EOF) begin
        ovf <= 1'b1;
        if (pos != '0) begin
          frame_valid <= 1'b1;
          frame_data  <= shreg;
          frame_len   <= pos;
          shreg       <= '0;
          pos         <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tx_data <= '0;
      last    <= '0;
      idx     <= '0;
      bt      <= '0;
    end else begin
      case (st)
        S_IDLE: if (rsp_valid) begin
          tx_data <= rsp_data;
          last    <= IW'(SOF_BITS - 1) + IW'(eff_len);
          st      <= S_WAIT;
        end
        S_WAIT: if (tick && cnt == C_GO) begin
          st  <= S_SEND;
          idx <= '0;
          bt  <= '0;
        end
        S_SEND: if (tick) begin
          if (bt == B_END) begin
            bt <= '0;
            if (idx == last) st <= S_IDLE;
            else idx <= idx + 1'b1;
          end else begin
            bt <= bt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OPEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sending |-> !coil_load); // R10
  AST_REPLY_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $rose(sending) |-> cnt == CW'(T_REPLY)); // R7
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |=> !frame_valid); // R4
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n) frame_valid |-> (frame_len != '0 && frame_len <= L_MAX)); // R6
  AST_BIT_TIMER: assert property (@(posedge clk) disable iff (!rst_n) sending |-> bt <= B_END); // R9
  AST_DEAF_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> pos <= $past(pos)); // R11
endmodule

// File: tb/lf_gap_responder_test.sv
module lf_gap_responder_test;
  localparam int D = 4;
  localparam int BITP = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_in = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [79:0] rsp_data = '0;
  logic [6:0]  rsp_len = '0;
  logic        coil_load, frame_valid;
  logic [79:0] frame_data;
  logic [6:0]  frame_len;

  lf_gap_responder #(.DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .field_in(field_in), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_len(rsp_len), .coil_load(coil_load),
    .frame_valid(frame_valid), .frame_data(frame_data), .frame_len(frame_len)
  );

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, tr = 0;
  bit done = 0;
  int gq[$];
  bit eq[$];
  bit [79:0] got_d[$];
  int got_l[$];

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // behavioural reference, advanced on every clock edge
  int  m_div, m_cnt, m_pos, m_st, m_bt, m_idx, m_last, m_fl;
  bit  m_f1, m_f2, m_f3, m_ovf, m_fv;
  bit [79:0] m_buf, m_fd, m_tx;

  function automatic bit m_coil();
    bit b;
    b = (m_idx < 5) ? 1'b1 : m_tx[79 - (m_idx - 5)];
    return (m_st == 2) && (b ? (m_bt < 15) : (m_bt >= 15));
  endfunction

  always @(posedge clk) begin : model
    bit rs, tk;
    int ocnt, ost;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_pos = 0; m_st = 0; m_bt = 0; m_idx = 0; m_last = 0;
      m_fl = 0; m_f1 = 0; m_f2 = 0; m_f3 = 0; m_ovf = 1; m_fv = 0;
      m_buf = '0; m_fd = '0; m_tx = '0;
    end else begin
      rs = m_f2 && !m_f3;
      tk = (m_div == D - 1);
      ocnt = m_cnt;
      ost = m_st;
      m_fv = 0;
      if (rs && ost == 0) begin
        if (!m_ovf && ocnt >= 15 && ocnt <= 40 && m_pos < 80) begin
          m_buf[79 - m_pos] = (ocnt >= 24);
          m_pos++;
        end
        m_ovf = 0;
      end else if (ocnt > 40) begin
        m_ovf = 1;
        if (m_pos > 0) begin
          m_fv = 1; m_fd = m_buf; m_fl = m_pos; m_buf = '0; m_pos = 0;
        end
      end
      case (ost)
        0: if (rsp_valid) begin
          m_tx = rsp_data;
          m_last = 4 + ((rsp_len > 80) ? 80 : int'(rsp_len));
          m_st = 1;
        end
        1: if (tk && ocnt == 199) begin m_st = 2; m_bt = 0; m_idx = 0; end
        default: if (tk) begin
          if (m_bt == BITP - 1) begin
            m_bt = 0;
            if (m_idx == m_last) m_st = 0; else m_idx++;
          end else m_bt++;
        end
      endcase
      if (rs && ost == 0) m_cnt = tk ? 1 : 0;
      else m_cnt = (ocnt + (tk ? 1 : 0)) % 256;
      m_f3 = m_f2; m_f2 = m_f1; m_f1 = field_in; m_div = (m_div + 1) % D;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 coil vs model", coil_load, m_coil());
      chk("R4 frame_valid vs model", frame_valid, m_fv);
      if (frame_valid) begin
        chk("R6 frame_data vs model", frame_data, m_fd);
        chk("R4 frame_len vs model", frame_len, m_fl);
        got_d.push_back(frame_data);
        got_l.push_back(int'(frame_len));
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_gaps;
    field_in = 1'b1; tr = cyc;
    foreach (gq[i]) begin
      step(3 * D); field_in = 1'b0;
      step((gq[i] - 3) * D); field_in = 1'b1; tr = cyc;
    end
    step(3 * D); field_in = 1'b0;
  endtask

  task automatic expect_frame(input string req);
    step(50 * D);
    if (got_l.size() == 0) begin
      chk(req, 0, 1);
    end else begin
      bit [79:0] d;
      int l;
      d = got_d.pop_front();
      l = got_l.pop_front();
      chk(req, l, eq.size());
      foreach (eq[i]) chk(req, d[79 - i], eq[i]);
    end
  endtask

  task automatic request(input logic [79:0] d, input int len);
    rsp_data = d; rsp_len = 7'(len); rsp_valid = 1'b1;
    step(1);
    rsp_valid = 1'b0;
  endtask

  task automatic capture;
    bit v[$];
    int ones;
    int tc;
    for (int j = 0; j < 400 * D && !coil_load; j++) step(1);
    tc = cyc;
    chk("R7 reply start", (tc - tr >= 199 * D && tc - tr <= 201 * D + 4), 1);
    for (int j = 0; j < eq.size() * BITP * D; j++) begin
      v.push_back(coil_load);
      step(1);
    end
    foreach (eq[k]) begin
      chk("R8 reply bit", v[k * BITP * D + 7 * D], eq[k]);
      chk("R9 second half", v[k * BITP * D + 23 * D], !eq[k]);
    end
    ones = 0;
    for (int j = 0; j < 40 * D; j++) begin
      if (coil_load) ones++;
      step(1);
    end
    chk("R10 open after reply", ones, 0);
  endtask

  task automatic noise;
    step(10 * D);
    for (int i = 0; i < 12; i++) begin
      field_in = 1'b1; step(3 * D);
      field_in = 1'b0; step(17 * D);
      if (i == 2 || i == 9) request({80{1'b0}}, 9);
    end
  endtask

  initial begin
    #(4 * 200000);
    chk("watchdog", 0, 1);
    report();
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(2);
    chk("R1 coil after reset", coil_load, 0);
    chk("R1 frame_valid after reset", frame_valid, 0);
    chk("R1 frame_len after reset", frame_len, 0);

    gq = {20, 30, 15, 23, 24, 40}; send_gaps();
    eq = {0, 1, 0, 0, 1, 1}; expect_frame("R2 thresholds");

    gq = {20, 14, 26}; send_gaps();
    eq = {0, 1}; expect_frame("R3 short interval");

    gq = {20, 276, 30}; send_gaps();
    eq = {0}; expect_frame("R4 first frame");
    eq = {1}; expect_frame("R5 wrapped interval dropped");

    gq.delete();
    for (int i = 0; i < 85; i++) gq.push_back((i % 3 == 0) ? 30 : 20);
    send_gaps();
    eq.delete();
    for (int i = 0; i < 80; i++) eq.push_back(i % 3 == 0);
    expect_frame("R6 80-bit limit");

    gq = {24, 15}; send_gaps();
    eq = {1, 0}; expect_frame("R4 frame before reply");
    request({6'b101100, 74'h0}, 6);
    eq = {1, 1, 1, 1, 1, 1, 0, 1, 1, 0, 0};
    fork
      capture();
      noise();
    join
    step(60 * D);
    chk("R11 no frame from edges during reply", got_l.size(), 0);

    gq = {30}; send_gaps();
    eq = {1}; expect_frame("R4 frame before empty reply");
    request({80{1'b1}}, 0);
    eq = {1, 1, 1, 1, 1};
    capture();

    step(20);
    report();
  end
endmodule